// File: doc/BRIEF.md
# Gated Event Counter Bank

This block holds a set of programmable event counters for performance monitoring. Each counter picks one line from a 16-wide event vector and adds one for every cycle that line is high. A counter moves only when its own enable bit is set and a global count-enable bit is also set. Software reaches the counters through a simple register port: a write strobe with address and data, and a combinational read path with its own address.

The counters behave as if their clock is switched off while global counting is disabled. In that state a write to a count register is dropped, and the stored value stays readable and unchanged. An override bit lifts this restriction so that writes land at any time. There is no way to reset one counter by itself: a single reset-all bit clears every counter together. A counter that wraps from all-ones to zero sets its bit in an overflow status register. The interrupt output is the OR of all overflow bits whose mask bit is set.

Top module: `evt_cnt_bank`

## Requirements
- R1: There are eight 32-bit counters. Address bits [19:16] select a 64 KB window: windows 0 to 7 belong to counters 0 to 7, and window 8 holds the global registers. Bits [3:2] select a word. In a counter window, word 0 is config and word 1 is count. In the global window, word 0 is control, word 1 is overflow status, word 2 is interrupt mask and word 3 is override. After reset every register reads zero and irq is low.
- R2: In a counter's config word, bits [3:0] hold the event select (codes 0x0 to 0xf pick events[0] to events[15]) and bit 31 is the counter enable. Both fields read back as written.
- R3: A counter adds exactly one on each clock edge where control bit 0 (global enable) is 1, its own enable bit is 1 and its selected event is high.
- R4: A write to a count word is ignored while control bit 0 and override bit 3 are both 0. The counter then reads back its earlier value.
- R5: A write to a count word takes effect when control bit 0 is 1 or override bit 3 is 1. If an increment falls on the same edge, the written value wins.
- R6: Writing 1 to control bit 1 clears all eight counters at once. That bit reads 1 for one cycle and then clears itself. The clear takes priority over writes and increments.
- R7: A counter that increments from 0xFFFFFFFF becomes 0 and sets its bit in the overflow status word (bit j for counter j).
- R8: Writing 1 to a bit of the overflow status word clears that bit. A wrap on the same edge wins, and the bit stays set.
- R9: irq is high exactly when some overflow bit is set whose matching mask bit is 1.
- R10: While control bit 0 is 0, no counter advances, even if it is enabled and its event is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| events | input | 16 | Event lines that the counters can select |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 20 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 20 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Overflow interrupt |

## Verification
Two pairs of events can fall on the same clock edge. A software write to a count word can coincide with an increment of that counter. An overflow W1C clear can coincide with a wrap of the same counter. The bench provokes each pair by raising the selected event line in the same cycle that the write strobe is held. It then judges the result by reading back the count (the written value must stand) and the status bit (it must stay set). The reset-all pulse is also checked against held-high events, to confirm that the clear outranks counting.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    GREG_CTRL = 2'd0,
    GREG_OVF  = 2'd1,
    GREG_MASK = 2'd2,
    GREG_OVR  = 2'd3
  } greg_e;

  typedef enum logic [1:0] {
    CWORD_CFG = 2'd0,
    CWORD_CNT = 2'd1,
    CWORD_R2  = 2'd2,
    CWORD_R3  = 2'd3
  } cword_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_RST_BIT = 1;
  localparam int unsigned OVR_GATE_BIT = 3;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NEV    = 16,
  localparam int unsigned SEL_W = $clog2(NEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEV-1:0]    events,
  input  logic              glob_en,
  input  logic              gate_open,
  input  logic              clr_all,
  input  logic              cfg_we,
  input  logic              cnt_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count,
  output logic              en,
  output logic [SEL_W-1:0]  sel,
  output logic              wrap
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  function automatic logic at_top(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  logic [CNT_W-1:0] count_q;
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             tick;
  logic             wr_ok;

  assign tick  = glob_en & en_q & events[sel_q];
  assign wr_ok = cnt_we & gate_open;
  assign wrap  = tick & ~clr_all & ~wr_ok & at_top(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clr_all) begin
      count_q <= '0;
    end else if (wr_ok) begin
      count_q <= wdata[CNT_W-1:0];
    end else if (tick) begin
      count_q <= bump(count_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (cfg_we) begin
      en_q  <= wdata[DATA_W-1];
      sel_q <= wdata[SEL_W-1:0];
    end
  end

  assign count = count_q;
  assign en    = en_q;
  assign sel   = sel_q;
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_pkg::*;
#(
  parameter int unsigned NCNT   = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned WIN_W  = 16,
  localparam int unsigned WN_W  = ADDR_W - WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NCNT-1:0]   wrap,
  output logic [NCNT-1:0]   cfg_we,
  output logic [NCNT-1:0]   cnt_wr,
  output logic              glob_en,
  output logic              clr_all,
  output logic              ovr_gate,
  output logic [NCNT-1:0]   ovf_q,
  output logic [NCNT-1:0]   mask_q,
  output logic              irq
);
  logic [WN_W-1:0] win;
  logic [1:0]      word;
  logic            glob_hit;
  logic [NCNT-1:0] w1c;

  assign win      = wr_addr[ADDR_W-1:WIN_W];
  assign word     = wr_addr[3:2];
  assign glob_hit = wr_en && (win == WN_W'(NCNT));

  for (genvar j = 0; j < NCNT; j++) begin : g_dec
    assign cfg_we[j] = wr_en && (win == WN_W'(j)) && (cword_e'(word) == CWORD_CFG);
    assign cnt_wr[j] = wr_en && (win == WN_W'(j)) && (cword_e'(word) == CWORD_CNT);
  end

  assign w1c = (glob_hit && greg_e'(word) == GREG_OVF) ? wr_data[NCNT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en  <= 1'b0;
      clr_all  <= 1'b0;
      ovr_gate <= 1'b0;
      mask_q   <= '0;
      ovf_q    <= '0;
    end else begin
      clr_all <= 1'b0;
      if (glob_hit) begin
        unique case (greg_e'(word))
          GREG_CTRL: begin
            glob_en <= wr_data[CTRL_EN_BIT];
            clr_all <= wr_data[CTRL_RST_BIT];
          end
          GREG_MASK: mask_q   <= wr_data[NCNT-1:0];
          GREG_OVR:  ovr_gate <= wr_data[OVR_GATE_BIT];
          default: ;
        endcase
      end
      ovf_q <= (ovf_q & ~w1c) | wrap;
    end
  end

  assign irq = |(ovf_q & mask_q);
endmodule

// File: rtl/evt_rdmux.sv
module evt_rdmux
  import evt_pkg::*;
#(
  parameter int unsigned NCNT   = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned WIN_W  = 16,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned WN_W  = ADDR_W - WIN_W
) (
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic [NCNT-1:0][CNT_W-1:0]  cnt_q,
  input  logic [NCNT-1:0]             cfg_en,
  input  logic [NCNT-1:0][SEL_W-1:0]  cfg_sel,
  input  logic                        glob_en,
  input  logic                        clr_all,
  input  logic                        ovr_gate,
  input  logic [NCNT-1:0]             ovf_q,
  input  logic [NCNT-1:0]             mask_q,
  output logic [DATA_W-1:0]           rd_data
);
  logic [WN_W-1:0] win;
  logic [1:0]      word;

  assign win  = rd_addr[ADDR_W-1:WIN_W];
  assign word = rd_addr[3:2];

  always_comb begin
    rd_data = '0;
    if (win == WN_W'(NCNT)) begin
      unique case (greg_e'(word))
        GREG_CTRL: begin
          rd_data[CTRL_EN_BIT]  = glob_en;
          rd_data[CTRL_RST_BIT] = clr_all;
        end
        GREG_OVF:  rd_data[NCNT-1:0] = ovf_q;
        GREG_MASK: rd_data[NCNT-1:0] = mask_q;
        GREG_OVR:  rd_data[OVR_GATE_BIT] = ovr_gate;
        default: ;
      endcase
    end else begin
      for (int j = 0; j < NCNT; j++) begin
        if (win == WN_W'(j)) begin
          if (cword_e'(word) == CWORD_CFG) begin
            rd_data[SEL_W-1:0] = cfg_sel[j];
            rd_data[DATA_W-1]  = cfg_en[j];
          end else if (cword_e'(word) == CWORD_CNT) begin
            rd_data[CNT_W-1:0] = cnt_q[j];
          end
        end
      end
    end
  end
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank #(
  parameter int unsigned NCNT   = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NEV    = 16,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned WIN_W  = 16,
  localparam int unsigned SEL_W = $clog2(NEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEV-1:0]    events,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [NCNT-1:0][CNT_W-1:0] cnt_q;
  logic [NCNT-1:0][SEL_W-1:0] cfg_sel;
  logic [NCNT-1:0]            cfg_en;
  logic [NCNT-1:0]            cfg_we;
  logic [NCNT-1:0]            cnt_wr;
  logic [NCNT-1:0]            wrap;
  logic [NCNT-1:0]            ovf_q;
  logic [NCNT-1:0]            mask_q;
  logic                       glob_en;
  logic                       clr_all;
  logic                       ovr_gate;
  logic                       gate_open;

  assign gate_open = glob_en | ovr_gate;

  evt_regs #(
    .NCNT(NCNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_W(WIN_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wrap(wrap), .cfg_we(cfg_we), .cnt_wr(cnt_wr),
    .glob_en(glob_en), .clr_all(clr_all), .ovr_gate(ovr_gate),
    .ovf_q(ovf_q), .mask_q(mask_q), .irq(irq)
  );

  for (genvar j = 0; j < NCNT; j++) begin : g_cnt
    evt_counter #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .NEV(NEV)
    ) u_cnt (
      .clk(clk), .rst_n(rst_n), .events(events), .glob_en(glob_en),
      .gate_open(gate_open), .clr_all(clr_all), .cfg_we(cfg_we[j]),
      .cnt_we(cnt_wr[j]), .wdata(wr_data), .count(cnt_q[j]),
      .en(cfg_en[j]), .sel(cfg_sel[j]), .wrap(wrap[j])
    );
  end

  evt_rdmux #(
    .NCNT(NCNT), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .WIN_W(WIN_W), .SEL_W(SEL_W)
  ) u_rd (
    .rd_addr(rd_addr), .cnt_q(cnt_q), .cfg_en(cfg_en), .cfg_sel(cfg_sel),
    .glob_en(glob_en), .clr_all(clr_all), .ovr_gate(ovr_gate),
    .ovf_q(ovf_q), .mask_q(mask_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/evt_cnt_bank_chk.sv
module evt_cnt_bank_chk #(
  parameter int unsigned NCNT  = 8,
  parameter int unsigned CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [NCNT-1:0][CNT_W-1:0] cnt_q,
  input logic [NCNT-1:0]            cnt_wr,
  input logic [NCNT-1:0]            wrap,
  input logic [NCNT-1:0]            ovf_q,
  input logic [NCNT-1:0]            mask_q,
  input logic                       glob_en,
  input logic                       ovr_gate,
  input logic                       clr_all,
  input logic                       irq
);
  for (genvar j = 0; j < NCNT; j++) begin : g_chk
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_all && !cnt_wr[j]) |=>
        (cnt_q[j] == $past(cnt_q[j]) || cnt_q[j] == $past(cnt_q[j]) + CNT_W'(1)));

    p_gated_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en && !ovr_gate && !clr_all) |=> (cnt_q[j] == $past(cnt_q[j])));

    p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (cnt_q[j] == '0));

    p_wrap_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[j] |=> ovf_q[j]);
  end

  p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !wr_en) |=> !clr_all);

  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind evt_cnt_bank evt_cnt_bank_chk #(.NCNT(NCNT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cnt_q(cnt_q), .cnt_wr(cnt_wr),
  .wrap(wrap), .ovf_q(ovf_q), .mask_q(mask_q), .glob_en(glob_en),
  .ovr_gate(ovr_gate), .clr_all(clr_all), .irq(irq)
);

// File: tb/evt_cnt_bank_test.sv
module evt_cnt_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] events = '0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [19:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  localparam logic [19:0] A_CTRL = 20'h8_0000;
  localparam logic [19:0] A_OVF  = 20'h8_0004;
  localparam logic [19:0] A_MASK = 20'h8_0008;
  localparam logic [19:0] A_OVR  = 20'h8_000C;

  evt_cnt_bank uut (
    .clk(clk), .rst_n(rst_n), .events(events), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [19:0] cfg_a(input int j);
    return 20'(j) << 16;
  endfunction
  function automatic logic [19:0] cnt_a(input int j);
    return (20'(j) << 16) | 20'h4;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [19:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic pulse_ev(input int bitn, input int n);
    @(negedge clk);
    events[bitn] = 1'b1;
    repeat (n) @(negedge clk);
    events[bitn] = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl after reset", A_CTRL, 32'h0);
    rd_chk("R1 count0 after reset", cnt_a(0), 32'h0);
    rd_chk("R1 ovf after reset", A_OVF, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_cfg;
    wr(cfg_a(2), 32'h8000_0005);
    rd_chk("R2 cfg readback", cfg_a(2), 32'h8000_0005);
  endtask

  task automatic t_gated_write;
    wr(A_CTRL, 32'h0);
    wr(cnt_a(3), 32'h0000_1234);
    rd_chk("R4 gated write dropped", cnt_a(3), 32'h0);
    wr(A_CTRL, 32'h1);
    wr(cnt_a(3), 32'h0000_1234);
    rd_chk("R5 write with count enable", cnt_a(3), 32'h0000_1234);
  endtask

  task automatic t_count;
    wr(cfg_a(0), 32'h8000_0003);
    wr(cfg_a(1), 32'h8000_0004);
    pulse_ev(3, 5);
    rd_chk("R3 count five events", cnt_a(0), 32'd5);
    rd_chk("R3 other select unaffected", cnt_a(1), 32'd0);
  endtask

  task automatic t_halt;
    wr(A_CTRL, 32'h0);
    pulse_ev(3, 4);
    rd_chk("R10 no count while disabled", cnt_a(0), 32'd5);
  endtask

  task automatic t_override;
    wr(A_OVR, 32'h8);
    rd_chk("R5 override readback", A_OVR, 32'h8);
    wr(cnt_a(3), 32'h55);
    rd_chk("R5 override write lands", cnt_a(3), 32'h55);
    wr(A_OVR, 32'h0);
  endtask

  task automatic t_write_vs_inc;
    wr(A_CTRL, 32'h1);
    @(negedge clk);
    events[3] = 1'b1;
    wr(cnt_a(0), 32'd100);
    events[3] = 1'b0;
    rd_chk("R5 write wins over increment", cnt_a(0), 32'd100);
  endtask

  task automatic t_overflow;
    wr(A_MASK, 32'h1);
    wr(cnt_a(0), 32'hFFFF_FFFE);
    pulse_ev(3, 2);
    rd_chk("R7 wrap to zero", cnt_a(0), 32'h0);
    rd_chk("R7 overflow bit set", A_OVF, 32'h1);
    check("R9 irq on unmasked overflow", {31'b0, irq}, 32'h1);
    wr(A_OVF, 32'h1);
    rd_chk("R8 W1C clears", A_OVF, 32'h0);
    check("R9 irq drops after clear", {31'b0, irq}, 32'h0);
    wr(A_MASK, 32'h0);
    wr(cnt_a(0), 32'hFFFF_FFFF);
    pulse_ev(3, 1);
    rd_chk("R7 overflow bit set again", A_OVF, 32'h1);
    check("R9 masked overflow quiet", {31'b0, irq}, 32'h0);
    wr(A_MASK, 32'h1);
    check("R9 irq after unmask", {31'b0, irq}, 32'h1);
    wr(A_OVF, 32'h1);
  endtask

  task automatic t_set_vs_clear;
    wr(cnt_a(0), 32'hFFFF_FFFF);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_OVF; wr_data = 32'h1; events[3] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; events[3] = 1'b0;
    rd_chk("R8 wrap wins over W1C", A_OVF, 32'h1);
    rd_chk("R7 count wrapped", cnt_a(0), 32'h0);
  endtask

  task automatic t_reset_all;
    wr(cnt_a(0), 32'd77);
    @(negedge clk);
    events[3] = 1'b1;
    wr(A_CTRL, 32'h3);
    rd_chk("R6 reset bit visible one cycle", A_CTRL, 32'h3);
    @(negedge clk);
    events[3] = 1'b0;
    rd_chk("R6 reset bit self-cleared", A_CTRL, 32'h1);
    rd_chk("R6 counter0 cleared", cnt_a(0), 32'h0);
    rd_chk("R6 counter3 cleared", cnt_a(3), 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_gated_write();
    t_count();
    t_halt();
    t_override();
    t_write_vs_inc();
    t_overflow();
    t_set_vs_clear();
    t_reset_all();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule